// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a 63-bit cycle count that advances by one on every enable pulse, together with a 63-bit compare limit. A single disable flag is shared by both registers and is carried in the top bit of each 64-bit write word. Reads of the count return the count with the flag ORed into the top bit. When the limit is armed, the timer is enabled and the count has reached the limit, the comparator raises a one-cycle match pulse. That pulse sets a sticky soft-interrupt bit, which stays set until software clears it.

The same module serves three roles, chosen by a parameter. The plain tick instance drives soft bit 0. The system-tick and hypervisor system-tick instances both drive soft bit 1. A limit of zero never arms the comparator. A limit at or below the current count fires in the cycle right after it is written. After a match, the comparator stays idle until the limit is written again.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is zero, the disable flag is set (cnt_o = 0x8000_0000_0000_0000), match_o is low and both soft bits are clear.
- R2: With no count write, each cycle with inc_i high adds one to the count. The count wraps from 0x7FFF_FFFF_FFFF_FFFF to zero.
- R3: A count write loads bits 62:0 of cnt_wdata_i as the new count and takes bit 63 as the disable flag. It overrides inc_i in the same cycle.
- R4: cnt_o bits 62:0 carry the current count and cnt_o bit 63 carries the disable flag.
- R5: A limit write stores bits 62:0 of lim_wdata_i as the compare value and takes bit 63 as the disable flag. It arms the comparator when the stored value is nonzero.
- R6: match_o is high for exactly one cycle when the comparator is armed, the flag is clear and the count is greater than or equal to the limit. After that pulse the comparator stays disarmed until the next limit write.
- R7: A zero limit never produces a match. While the flag is set, no match occurs. A later count write that clears the flag lets a still-armed compare fire.
- R8: A limit written at or below the current count, with the flag clear, gives match_o high in the cycle right after the write.
- R9: A match sets soft bit 0 when KIND is KIND_TICK and soft bit 1 when KIND is KIND_SYS. The other bit is left unchanged, and the set bit stays set.
- R10: A high bit of soft_clr_i clears the matching soft bit at the next edge. A match in the same cycle wins over the clear.
- R11: When count and limit are written in the same cycle, the disable flag comes from bit 63 of lim_wdata_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Count enable pulse |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 64 | Count write word, bit 63 is the disable flag |
| lim_we_i | input | 1 | Limit write strobe |
| lim_wdata_i | input | 64 | Limit write word, bit 63 is the disable flag |
| soft_clr_i | input | 2 | Per-bit clear for the soft-interrupt bits |
| cnt_o | output | 64 | Count read value with the disable flag in bit 63 |
| match_o | output | 1 | One-cycle compare match pulse |
| soft_o | output | 2 | Sticky soft-interrupt bits (bit 0 tick, bit 1 system tick) |

## Verification
Some properties are checked by assertions on every cycle: a count write loads its value, a bare increment adds one, the limit write's flag wins a shared cycle, the match is a single pulse, no match appears while the flag is set or after a zero limit, and a match always leaves its soft bit set. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model. These cover the wrap at the top of the count, a late limit firing in the very next cycle, re-enabling through a count write, the set-over-clear race on the soft bits, and the different soft bit driven by a system-tick instance.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic {
    KIND_TICK = 1'b0,
    KIND_SYS  = 1'b1
  } tick_kind_e;

  localparam int unsigned SOFT_W = 2;
endpackage

// File: rtl/tick_count_reg.sv
module tick_count_reg #(
  parameter int unsigned CNT_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W:0]   cnt_wdata_i,
  input  logic             lim_we_i,
  input  logic             lim_dis_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dis_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dis_q <= 1'b1;
    end else begin
      if (cnt_we_i)   cnt_q <= cnt_wdata_i[CNT_W-1:0];
      else if (inc_i) cnt_q <= cnt_q + ONE;
      // limit write owns the flag on a shared cycle
      if (lim_we_i)      dis_q <= lim_dis_i;
      else if (cnt_we_i) dis_q <= cnt_wdata_i[CNT_W];
    end
  end

  assign cnt_o = cnt_q;
  assign dis_o = dis_q;

  a_r3_count_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(cnt_wdata_i[CNT_W-1:0]));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && inc_i) |=> cnt_q == $past(cnt_q) + ONE);
  a_r11_flag_from_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i |=> dis_q == $past(lim_dis_i));
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int unsigned CNT_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dis_i,
  input  logic             lim_we_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             match_o
);
  logic [CNT_W-1:0] lim_q;
  logic             arm_q;

  assign match_o = arm_q & ~dis_i & (cnt_i >= lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      arm_q <= 1'b0;
    end else if (lim_we_i) begin
      lim_q <= lim_i;
      arm_q <= |lim_i;
    end else if (match_o) begin
      arm_q <= 1'b0;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !lim_we_i) |=> !match_o);
  a_r7_zero_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_we_i && lim_i == '0) |=> !match_o);
endmodule

// File: rtl/tick_soft_bits.sv
module tick_soft_bits #(
  parameter int unsigned SOFT_W = 2,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              match_i,
  input  logic [SOFT_W-1:0] clr_i,
  output logic [SOFT_W-1:0] soft_o
);
  logic [SOFT_W-1:0] soft_q, soft_d;

  always_comb begin
    soft_d      = soft_q & ~clr_i;
    soft_d[IDX] = soft_d[IDX] | match_i;  // set wins over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_q <= '0;
    else         soft_q <= soft_d;
  end

  assign soft_o = soft_q;

  a_r9_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> soft_q[IDX]);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[IDX] && !match_i) |=> !soft_q[IDX]);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = 63,
  parameter tick_kind_e  KIND  = KIND_TICK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W:0]    cnt_wdata_i,
  input  logic              lim_we_i,
  input  logic [CNT_W:0]    lim_wdata_i,
  input  logic [SOFT_W-1:0] soft_clr_i,
  output logic [CNT_W:0]    cnt_o,
  output logic              match_o,
  output logic [SOFT_W-1:0] soft_o
);
  localparam int unsigned SOFT_IDX = (KIND == KIND_TICK) ? 0 : 1;

  logic [CNT_W-1:0] cnt;
  logic             dis;

  tick_count_reg #(.CNT_W(CNT_W)) i_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_i       (inc_i),
    .cnt_we_i    (cnt_we_i),
    .cnt_wdata_i (cnt_wdata_i),
    .lim_we_i    (lim_we_i),
    .lim_dis_i   (lim_wdata_i[CNT_W]),
    .cnt_o       (cnt),
    .dis_o       (dis)
  );

  tick_compare #(.CNT_W(CNT_W)) i_compare (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt),
    .dis_i    (dis),
    .lim_we_i (lim_we_i),
    .lim_i    (lim_wdata_i[CNT_W-1:0]),
    .match_o  (match_o)
  );

  tick_soft_bits #(.SOFT_W(SOFT_W), .IDX(SOFT_IDX)) i_soft (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match_o),
    .clr_i   (soft_clr_i),
    .soft_o  (soft_o)
  );

  assign cnt_o = {dis, cnt};

  a_r7_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o[CNT_W] |-> !match_o);
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  import tick_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inc_i = 1'b0, cnt_we_i = 1'b0, lim_we_i = 1'b0;
  logic [63:0] cnt_wdata_i = '0, lim_wdata_i = '0;
  logic [1:0]  soft_clr_i = '0;
  logic [63:0] cnt_o, cnt2_o;
  logic        match_o, match2_o;
  logic [1:0]  soft_o, soft2_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  logic [62:0] m_cnt = '0;
  logic [62:0] m_lim = '0;
  logic        m_dis = 1'b1;
  logic        m_arm = 1'b0;
  logic [1:0]  m_soft = '0, m_soft2 = '0;

  always #2.5 clk_i = ~clk_i;

  tick_timer #(.KIND(KIND_TICK)) i_tick_timer (
    .clk_i, .rst_ni, .inc_i, .cnt_we_i, .cnt_wdata_i, .lim_we_i, .lim_wdata_i,
    .soft_clr_i, .cnt_o, .match_o, .soft_o
  );

  tick_timer #(.KIND(KIND_SYS)) i_tick_timer_sys (
    .clk_i, .rst_ni, .inc_i, .cnt_we_i, .cnt_wdata_i, .lim_we_i, .lim_wdata_i,
    .soft_clr_i, .cnt_o(cnt2_o), .match_o(match2_o), .soft_o(soft2_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      summary();
    end
  end

  // called at a negedge: drive, check pre-edge match, step model, check post-edge state
  task automatic cyc(input logic inc, input logic cw, input logic [63:0] cd,
                     input logic lw, input logic [63:0] ld, input logic [1:0] clr,
                     input string tag);
    logic fire;
    inc_i = inc; cnt_we_i = cw; cnt_wdata_i = cd;
    lim_we_i = lw; lim_wdata_i = ld; soft_clr_i = clr;
    fire = m_arm && !m_dis && (m_cnt >= m_lim);
    chk({tag, " R6 match"}, {63'd0, match_o}, {63'd0, fire});
    chk({tag, " R9 match sys"}, {63'd0, match2_o}, {63'd0, fire});
    if (cw) m_cnt = cd[62:0];
    else if (inc) m_cnt = m_cnt + 63'd1;
    if (lw) m_dis = ld[63];
    else if (cw) m_dis = cd[63];
    if (lw) begin m_lim = ld[62:0]; m_arm = (ld[62:0] != '0); end
    else if (fire) m_arm = 1'b0;
    m_soft  = (m_soft  & ~clr) | (fire ? 2'b01 : 2'b00);
    m_soft2 = (m_soft2 & ~clr) | (fire ? 2'b10 : 2'b00);
    @(posedge clk_i);
    @(negedge clk_i);
    chk({tag, " R4 count"}, cnt_o, {m_dis, m_cnt});
    chk({tag, " R4 count sys"}, cnt2_o, {m_dis, m_cnt});
    chk({tag, " R9 soft"}, {62'd0, soft_o}, {62'd0, m_soft});
    chk({tag, " R9 soft sys"}, {62'd0, soft2_o}, {62'd0, m_soft2});
  endtask

  task automatic idle(input int n, input logic inc, input string tag);
    for (int k = 0; k < n; k++) cyc(inc, 1'b0, '0, 1'b0, '0, 2'b00, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 count", cnt_o, 64'h8000_0000_0000_0000);
    chk("R1 match", {63'd0, match_o}, 64'd0);
    chk("R1 soft", {62'd0, soft_o}, 64'd0);

    idle(3, 1'b1, "R2 inc");
    cyc(1'b1, 1'b1, 64'd100, 1'b0, '0, 2'b00, "R3 load over inc");
    chk("R3 loaded", cnt_o, 64'd100);
    cyc(1'b0, 1'b0, '0, 1'b1, 64'd105, 2'b00, "R5 limit");
    idle(9, 1'b1, "R6 run to match");
    chk("R9 tick bit", {62'd0, soft_o}, 64'd1);
    chk("R9 sys bit", {62'd0, soft2_o}, 64'd2);
    idle(3, 1'b1, "R6 no refire");
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 2'b11, "R10 clear");
    chk("R10 cleared", {62'd0, soft_o}, 64'd0);

    cyc(1'b0, 1'b0, '0, 1'b1, 64'd50, 2'b00, "R8 late limit");
    chk("R8 fires next cycle", {63'd0, match_o}, 64'd1);
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 2'b11, "R10 set beats clear");
    chk("R10 set wins", {62'd0, soft_o}, 64'd1);
    idle(2, 1'b1, "R6 idle");

    cyc(1'b0, 1'b0, '0, 1'b1, 64'd0, 2'b11, "R7 zero limit");
    idle(3, 1'b1, "R7 zero quiet");
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h8000_0000_0000_0014, 2'b00, "R7 disabled limit");
    idle(2, 1'b1, "R7 disabled quiet");
    chk("R7 flag read", {63'd0, cnt_o[63]}, 64'd1);
    cyc(1'b0, 1'b1, 64'd200, 1'b0, '0, 2'b00, "R7 re-enable");
    chk("R7 armed fires", {63'd0, match_o}, 64'd1);
    idle(2, 1'b0, "R7 after");

    cyc(1'b0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFE, 1'b0, '0, 2'b00, "R2 near top");
    idle(3, 1'b1, "R2 wrap");
    chk("R2 wrapped", cnt_o, 64'd1);

    cyc(1'b0, 1'b1, 64'd5, 1'b1, 64'h8000_0000_0000_03E8, 2'b00, "R11 both writes");
    chk("R11 flag from limit", cnt_o, 64'h8000_0000_0000_0005);
    idle(2, 1'b1, "R11 after");
    summary();
  end
endmodule